// File: doc/BRIEF.md
# Tile-Write Bridge with Toggle Clock-Domain Handoff

This block is a single-beat AXI4 slave that lives in the host bridge clock domain. It offers two address regions. The first is a small, fixed identity window that software probes to learn which core is loaded. The second is a writable tile memory of 32-bit words. Every byte address outside these two regions reads as zero, and writes to it are acknowledged and dropped.

Each write that lands in the tile memory does two things. It updates the local copy, merged byte by byte under the write strobes. It also hands the resulting word to a consumer in another clock domain. The handoff flips a single toggle line. On that same bridge clock edge it registers the entry index and the full merged word on two output buses, which stay unchanged until the next tile write.

The receiver turns each toggle edge into a write pulse through its own synchronizer. Nothing at this block's edge limits the write rate, so the host must space tile writes at least three receiver clocks apart.

Top module: `tile_xfer_bridge`

## Requirements
- R1: After reset, AWREADY and ARREADY are high, BVALID and RVALID are low, and the toggle, index and data handoff outputs are all zero.
- R2: A write takes its address first (AWREADY is high only while idle), then its data beat (WREADY is high only after the address is taken). BVALID then stays high and BID stays stable until BREADY, and no new address is taken meanwhile.
- R3: After an address handshake, RVALID rises, and RVALID, RDATA and RID stay stable until RREADY. ARREADY is low while RVALID is high.
- R4: BID equals the AWID of the write it answers, and RID equals the ARID of the read it answers.
- R5: BRESP and RRESP are always 2'b00 (OKAY), and RLAST is always 1.
- R6: The identity window covers byte addresses 0x000 to 0x00F. Address bits [3:2] pick the word: 0 gives 0x70533200, 1 gives 0x00000100, 2 gives 0x00000001 and 3 gives 0x00000000. A read places the 32-bit word in the 128-bit lane that bits [3:2] select (lane n is RDATA[32n+31:32n]), and all other lanes are zero.
- R7: A read of any address outside both regions returns all zeros, including when address bits above bit 11 are set. A write outside the tile window is acknowledged with OKAY, leaves the toggle unchanged, and does not alter the identity words.
- R8: The tile window starts at byte address 0x1000 and holds 1024 entries at a 4-byte stride, with the index taken from address bits [11:2]. A read of an entry returns the last value written to it, in lane [3:2].
- R9: On a tile write, only WSTRB bits 4n..4n+3 of the selected lane n take effect, one bit per byte. Bytes whose strobe is clear keep their old value, and data in other lanes is ignored.
- R10: Every accepted tile write flips the toggle exactly once, on the edge where BVALID rises. On that same edge it loads the index output with the entry index and the data output with the merged word. The toggle never changes at any other time.
- R11: A receiver in a second clock domain uses a three-stage synchronizer with an edge detector on its last two stages. When tile writes are spaced at least three receiver clocks apart, it recovers every write with the correct index and data, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bridge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awid | input | 4 | Write address ID |
| s_awaddr | input | 38 | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 128 | Write data |
| s_wstrb | input | 16 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bid | output | 4 | Write response ID |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_arid | input | 4 | Read address ID |
| s_araddr | input | 38 | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rid | output | 4 | Read response ID |
| s_rdata | output | 128 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Last read beat |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| xd_toggle | output | 1 | Handoff toggle, flips once per tile write |
| xd_index | output | 10 | Tile index of the last tile write |
| xd_data | output | 32 | Merged word of the last tile write |

## Verification
Reads cover all four identity slots, so each lane placement is seen once. Unmapped reads probe just past the identity window, just past the tile window, and a high address bit set above a tile offset, which separates a full region decode from one that truncates high bits. The writes include:
- writes into the identity window and into unmapped space, to show that neither flips the toggle nor alters a readable word;
- full-lane tile writes at the first entry, the last entry and entries in every lane;
- a single-byte strobe that must merge with the stored word;
- a write whose strobes fall only in a lane other than the selected one, so the handoff must carry the old word unchanged.

A receiver model in a second clock domain, with its own clock period, replays every handoff into a shadow copy. This shows that index and data are valid whenever the toggle edge is seen.

// File: rtl/txb_pkg.sv
// Shared constants, state encodings and the identity word table for the
// tile-write bridge. Assumes 32-bit register words built from 8-bit bytes.
package txb_pkg;

    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = WORD_W / BYTE_W;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_DATA = 2'd1,
        WR_RESP = 2'd2
    } wr_state_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    // Fixed identity words, selected by the word slot within the window.
    function automatic logic [WORD_W-1:0] ident_word(input logic [1:0] slot);
        case (slot)
            2'd0:    return 32'h7053_3200;
            2'd1:    return 32'h0000_0100;
            2'd2:    return 32'h0000_0001;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage : txb_pkg

// File: rtl/txb_addr_decode.sv
// Region decoder: classifies a byte address as identity window, tile window
// or neither, and splits out the lane and the tile entry index.
// Assumes the tile base is aligned to the tile window span.
module txb_addr_decode #(
    parameter int                  ADDR_W    = 38,
    parameter int                  LANE_W    = 2,
    parameter int                  IDX_W     = 10,
    parameter logic [ADDR_W-1:0]   TILE_BASE = 38'h1000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_ident,
    output logic              is_tile,
    output logic [LANE_W-1:0] lane,
    output logic [IDX_W-1:0]  index
);
    localparam int IDENT_SPAN = LANE_W + 2;
    localparam int TILE_SPAN  = IDX_W + 2;

    // Region hits compare every address bit above the region span.
    assign is_ident = (addr[ADDR_W-1:IDENT_SPAN] == '0);
    assign is_tile  = (addr[ADDR_W-1:TILE_SPAN] == TILE_BASE[ADDR_W-1:TILE_SPAN]);

    // Lane and entry index fields of a word-aligned address.
    assign lane  = addr[IDENT_SPAN-1:2];
    assign index = addr[TILE_SPAN-1:2];

    logic unused_byte_offset;
    assign unused_byte_offset = ^addr[1:0];

endmodule : txb_addr_decode

// File: rtl/txb_tile_store.sv
// Tile word storage: one synchronous write port, two combinational read
// ports (one for the write-merge, one for the read channel).
// Contents are not cleared by reset.
module txb_tile_store #(
    parameter int DEPTH = 1024,
    parameter int IDX_W = 10
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [txb_pkg::WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]          rd_idx_a,
    output logic [txb_pkg::WORD_W-1:0] rd_word_a,
    input  logic [IDX_W-1:0]          rd_idx_b,
    output logic [txb_pkg::WORD_W-1:0] rd_word_b
);
    logic [txb_pkg::WORD_W-1:0] mem [DEPTH];

    // Store the merged word of an accepted tile write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_word;
        end
    end

    assign rd_word_a = mem[rd_idx_a];
    assign rd_word_b = mem[rd_idx_b];

endmodule : txb_tile_store

// File: rtl/txb_wr_path.sv
// Write channel: address beat, then data beat, then response held until
// BREADY. Merges the strobed lane bytes into the stored tile word and, on
// the accepting edge, flips the handoff toggle and registers index and data.
// Assumes single-beat writes only.
module txb_wr_path
    import txb_pkg::*;
#(
    parameter int                ADDR_W    = 38,
    parameter int                ID_W      = 4,
    parameter int                DATA_W    = 128,
    parameter int                IDX_W     = 10,
    parameter logic [ADDR_W-1:0] TILE_BASE = 38'h1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ID_W-1:0]      awid,
    input  logic [ADDR_W-1:0]    awaddr,
    input  logic                 awvalid,
    output logic                 awready,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W/8-1:0]  wstrb,
    input  logic                 wvalid,
    output logic                 wready,
    output logic [ID_W-1:0]      bid,
    output logic [1:0]           bresp,
    output logic                 bvalid,
    input  logic                 bready,
    output logic                 st_wr_en,
    output logic [IDX_W-1:0]     st_idx,
    output logic [WORD_W-1:0]    st_word,
    input  logic [WORD_W-1:0]    st_old_word,
    output logic                 xd_toggle,
    output logic [IDX_W-1:0]     xd_index,
    output logic [WORD_W-1:0]    xd_data
);
    localparam int LANES  = DATA_W / WORD_W;
    localparam int LANE_W = $clog2(LANES);

    wr_state_e         state;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;

    logic              q_tile;
    logic              q_ident_unused;
    logic [LANE_W-1:0] q_lane;
    logic [IDX_W-1:0]  q_idx;

    txb_addr_decode #(
        .ADDR_W   (ADDR_W),
        .LANE_W   (LANE_W),
        .IDX_W    (IDX_W),
        .TILE_BASE(TILE_BASE)
    ) i_wr_decode (
        .addr    (addr_q),
        .is_ident(q_ident_unused),
        .is_tile (q_tile),
        .lane    (q_lane),
        .index   (q_idx)
    );

    logic [WORD_W-1:0]     lane_word;
    logic [WORD_BYTES-1:0] lane_strb;
    logic [WORD_W-1:0]     merged;
    logic                  accept_w;

    assign lane_word = wdata[q_lane*WORD_W +: WORD_W];
    assign lane_strb = wstrb[q_lane*WORD_BYTES +: WORD_BYTES];

    // Byte merge: strobed bytes from the bus, the rest from the stored word.
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte_merge
        assign merged[b*BYTE_W +: BYTE_W] = lane_strb[b] ? lane_word[b*BYTE_W +: BYTE_W]
                                                         : st_old_word[b*BYTE_W +: BYTE_W];
    end

    assign accept_w = (state == WR_DATA) && wvalid;

    // Write channel sequencing: address, data, response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= WR_IDLE;
            id_q   <= '0;
            addr_q <= '0;
            bvalid <= 1'b0;
        end else begin
            case (state)
                WR_IDLE: begin
                    if (awvalid) begin
                        id_q   <= awid;
                        addr_q <= awaddr;
                        state  <= WR_DATA;
                    end
                end
                WR_DATA: begin
                    if (wvalid) begin
                        bvalid <= 1'b1;
                        state  <= WR_RESP;
                    end
                end
                WR_RESP: begin
                    if (bready) begin
                        bvalid <= 1'b0;
                        state  <= WR_IDLE;
                    end
                end
                default: state <= WR_IDLE;
            endcase
        end
    end

    // Cross-domain handoff: toggle, index and word move on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xd_toggle <= 1'b0;
            xd_index  <= '0;
            xd_data   <= '0;
        end else if (st_wr_en) begin
            xd_toggle <= ~xd_toggle;
            xd_index  <= q_idx;
            xd_data   <= merged;
        end
    end

    assign st_wr_en = accept_w && q_tile;
    assign st_idx   = q_idx;
    assign st_word  = merged;

    assign awready = (state == WR_IDLE);
    assign wready  = (state == WR_DATA);
    assign bid     = id_q;
    assign bresp   = RESP_OKAY;

endmodule : txb_wr_path

// File: rtl/txb_rd_path.sv
// Read channel: takes an address when idle, registers the lane-placed word
// (identity, tile or zero) and holds it until RREADY.
// Assumes single-beat reads only.
module txb_rd_path
    import txb_pkg::*;
#(
    parameter int                ADDR_W    = 38,
    parameter int                ID_W      = 4,
    parameter int                DATA_W    = 128,
    parameter int                IDX_W     = 10,
    parameter logic [ADDR_W-1:0] TILE_BASE = 38'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   arid,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [ID_W-1:0]   rid,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rlast,
    output logic              rvalid,
    input  logic              rready,
    output logic [IDX_W-1:0]  st_idx,
    input  logic [WORD_W-1:0] st_word
);
    localparam int LANES  = DATA_W / WORD_W;
    localparam int LANE_W = $clog2(LANES);

    rd_state_e         state;
    logic [ID_W-1:0]   id_q;
    logic [DATA_W-1:0] data_q;

    logic              a_ident;
    logic              a_tile;
    logic [LANE_W-1:0] a_lane;
    logic [IDX_W-1:0]  a_idx;
    logic [WORD_W-1:0] word_sel;

    txb_addr_decode #(
        .ADDR_W   (ADDR_W),
        .LANE_W   (LANE_W),
        .IDX_W    (IDX_W),
        .TILE_BASE(TILE_BASE)
    ) i_rd_decode (
        .addr    (araddr),
        .is_ident(a_ident),
        .is_tile (a_tile),
        .lane    (a_lane),
        .index   (a_idx)
    );

    // Word source by region; unmapped space reads zero.
    always_comb begin
        if (a_ident) begin
            word_sel = ident_word(2'(a_lane));
        end else if (a_tile) begin
            word_sel = st_word;
        end else begin
            word_sel = '0;
        end
    end

    // Read channel sequencing: capture, hold until accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RD_IDLE;
            id_q   <= '0;
            data_q <= '0;
            rvalid <= 1'b0;
        end else begin
            case (state)
                RD_IDLE: begin
                    if (arvalid) begin
                        id_q   <= arid;
                        data_q <= DATA_W'(word_sel) << (a_lane * WORD_W);
                        rvalid <= 1'b1;
                        state  <= RD_RESP;
                    end
                end
                RD_RESP: begin
                    if (rready) begin
                        rvalid <= 1'b0;
                        state  <= RD_IDLE;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    assign st_idx  = a_idx;
    assign arready = (state == RD_IDLE);
    assign rid     = id_q;
    assign rdata   = data_q;
    assign rresp   = RESP_OKAY;
    assign rlast   = 1'b1;

endmodule : txb_rd_path

// File: rtl/tile_xfer_bridge.sv
// Top of the tile-write bridge: single-beat AXI4 slave with an identity
// window and a tile memory whose writes are handed to another clock domain
// through a toggle plus registered index and word.
// Assumes the host spaces tile writes for the receiver's synchronizer.
module tile_xfer_bridge #(
    parameter int                ADDR_W     = 38,
    parameter int                ID_W       = 4,
    parameter int                DATA_W     = 128,
    parameter int                TILE_DEPTH = 1024,
    parameter logic [ADDR_W-1:0] TILE_BASE  = 38'h1000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ID_W-1:0]               s_awid,
    input  logic [ADDR_W-1:0]             s_awaddr,
    input  logic                          s_awvalid,
    output logic                          s_awready,
    input  logic [DATA_W-1:0]             s_wdata,
    input  logic [DATA_W/8-1:0]           s_wstrb,
    input  logic                          s_wvalid,
    output logic                          s_wready,
    output logic [ID_W-1:0]               s_bid,
    output logic [1:0]                    s_bresp,
    output logic                          s_bvalid,
    input  logic                          s_bready,
    input  logic [ID_W-1:0]               s_arid,
    input  logic [ADDR_W-1:0]             s_araddr,
    input  logic                          s_arvalid,
    output logic                          s_arready,
    output logic [ID_W-1:0]               s_rid,
    output logic [DATA_W-1:0]             s_rdata,
    output logic [1:0]                    s_rresp,
    output logic                          s_rlast,
    output logic                          s_rvalid,
    input  logic                          s_rready,
    output logic                          xd_toggle,
    output logic [$clog2(TILE_DEPTH)-1:0] xd_index,
    output logic [txb_pkg::WORD_W-1:0]    xd_data
);
    localparam int IDX_W = $clog2(TILE_DEPTH);

    logic                       st_wr_en;
    logic [IDX_W-1:0]           st_wr_idx;
    logic [txb_pkg::WORD_W-1:0] st_wr_word;
    logic [txb_pkg::WORD_W-1:0] st_old_word;
    logic [IDX_W-1:0]           st_rd_idx;
    logic [txb_pkg::WORD_W-1:0] st_rd_word;

    txb_tile_store #(
        .DEPTH(TILE_DEPTH),
        .IDX_W(IDX_W)
    ) i_store (
        .clk      (clk),
        .wr_en    (st_wr_en),
        .wr_idx   (st_wr_idx),
        .wr_word  (st_wr_word),
        .rd_idx_a (st_wr_idx),
        .rd_word_a(st_old_word),
        .rd_idx_b (st_rd_idx),
        .rd_word_b(st_rd_word)
    );

    txb_wr_path #(
        .ADDR_W   (ADDR_W),
        .ID_W     (ID_W),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .TILE_BASE(TILE_BASE)
    ) i_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .awid       (s_awid),
        .awaddr     (s_awaddr),
        .awvalid    (s_awvalid),
        .awready    (s_awready),
        .wdata      (s_wdata),
        .wstrb      (s_wstrb),
        .wvalid     (s_wvalid),
        .wready     (s_wready),
        .bid        (s_bid),
        .bresp      (s_bresp),
        .bvalid     (s_bvalid),
        .bready     (s_bready),
        .st_wr_en   (st_wr_en),
        .st_idx     (st_wr_idx),
        .st_word    (st_wr_word),
        .st_old_word(st_old_word),
        .xd_toggle  (xd_toggle),
        .xd_index   (xd_index),
        .xd_data    (xd_data)
    );

    txb_rd_path #(
        .ADDR_W   (ADDR_W),
        .ID_W     (ID_W),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .TILE_BASE(TILE_BASE)
    ) i_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .arid   (s_arid),
        .araddr (s_araddr),
        .arvalid(s_arvalid),
        .arready(s_arready),
        .rid    (s_rid),
        .rdata  (s_rdata),
        .rresp  (s_rresp),
        .rlast  (s_rlast),
        .rvalid (s_rvalid),
        .rready (s_rready),
        .st_idx (st_rd_idx),
        .st_word(st_rd_word)
    );

endmodule : tile_xfer_bridge

// File: rtl/txb_bridge_chk.sv
// Protocol and handoff checker for the tile-write bridge, bound to the top.
// Tracks accepted request IDs and the tile-ness of the pending write itself.
module txb_bridge_chk #(
    parameter int                ADDR_W    = 38,
    parameter int                ID_W      = 4,
    parameter int                DATA_W    = 128,
    parameter int                IDX_W     = 10,
    parameter logic [ADDR_W-1:0] TILE_BASE = 38'h1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ID_W-1:0]   s_awid,
    input logic [ADDR_W-1:0] s_awaddr,
    input logic              s_awvalid,
    input logic              s_awready,
    input logic              s_wready,
    input logic [ID_W-1:0]   s_bid,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic [ID_W-1:0]   s_arid,
    input logic              s_arvalid,
    input logic              s_arready,
    input logic [ID_W-1:0]   s_rid,
    input logic [DATA_W-1:0] s_rdata,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic              xd_toggle
);
    localparam int TILE_SPAN = IDX_W + 2;

    logic            in_reset_q;
    logic [ID_W-1:0] aw_id_q;
    logic [ID_W-1:0] ar_id_q;
    logic            aw_tile_q;

    logic unused_chk_bits;
    assign unused_chk_bits = ^s_awaddr[TILE_SPAN-1:0];

    // Remember that the previous edge was in reset.
    always_ff @(posedge clk) begin
        in_reset_q <= !rst_n;
    end

    // Shadow the accepted request IDs and the write's region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_id_q   <= '0;
            ar_id_q   <= '0;
            aw_tile_q <= 1'b0;
        end else begin
            if (s_awvalid && s_awready) begin
                aw_id_q   <= s_awid;
                aw_tile_q <= (s_awaddr[ADDR_W-1:TILE_SPAN] == TILE_BASE[ADDR_W-1:TILE_SPAN]);
            end
            if (s_arvalid && s_arready) begin
                ar_id_q <= s_arid;
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_reset_q |-> (s_awready && s_arready && !s_bvalid && !s_rvalid && !xd_toggle));

    assert_no_aw_in_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> (!s_awready && !s_wready));

    assert_data_after_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awvalid && s_awready) |=> s_wready);

    assert_b_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bid)));

    assert_r_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rid)));

    assert_no_ar_in_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> !s_arready);

    assert_bid_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_bvalid) |-> (s_bid == aw_id_q));

    assert_rid_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_rvalid) |-> (s_rid == ar_id_q));

    assert_quiet_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_bvalid) && !aw_tile_q) |-> $stable(xd_toggle));

    assert_toggle_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xd_toggle != $past(xd_toggle)) |-> $rose(s_bvalid));

    assert_toggle_on_tile_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_bvalid) && aw_tile_q) |-> (xd_toggle != $past(xd_toggle)));

endmodule : txb_bridge_chk

bind tile_xfer_bridge txb_bridge_chk #(
    .ADDR_W   (ADDR_W),
    .ID_W     (ID_W),
    .DATA_W   (DATA_W),
    .IDX_W    ($clog2(TILE_DEPTH)),
    .TILE_BASE(TILE_BASE)
) i_txb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_awid   (s_awid),
    .s_awaddr (s_awaddr),
    .s_awvalid(s_awvalid),
    .s_awready(s_awready),
    .s_wready (s_wready),
    .s_bid    (s_bid),
    .s_bvalid (s_bvalid),
    .s_bready (s_bready),
    .s_arid   (s_arid),
    .s_arvalid(s_arvalid),
    .s_arready(s_arready),
    .s_rid    (s_rid),
    .s_rdata  (s_rdata),
    .s_rvalid (s_rvalid),
    .s_rready (s_rready),
    .xd_toggle(xd_toggle)
);

// File: tb/test_tile_xfer_bridge.sv
module test_tile_xfer_bridge;

    localparam int ADDR_W = 38;
    localparam int ID_W   = 4;
    localparam int DATA_W = 128;
    localparam int DEPTH  = 1024;

    logic clk   = 1'b0;
    logic rclk  = 1'b0;
    logic rst_n = 1'b0;

    always #4 clk = ~clk;
    always #5.5 rclk = ~rclk;

    logic [ID_W-1:0]     s_awid    = '0;
    logic [ADDR_W-1:0]   s_awaddr  = '0;
    logic                s_awvalid = 1'b0;
    logic                s_awready;
    logic [DATA_W-1:0]   s_wdata   = '0;
    logic [DATA_W/8-1:0] s_wstrb   = '0;
    logic                s_wvalid  = 1'b0;
    logic                s_wready;
    logic [ID_W-1:0]     s_bid;
    logic [1:0]          s_bresp;
    logic                s_bvalid;
    logic                s_bready  = 1'b0;
    logic [ID_W-1:0]     s_arid    = '0;
    logic [ADDR_W-1:0]   s_araddr  = '0;
    logic                s_arvalid = 1'b0;
    logic                s_arready;
    logic [ID_W-1:0]     s_rid;
    logic [DATA_W-1:0]   s_rdata;
    logic [1:0]          s_rresp;
    logic                s_rlast;
    logic                s_rvalid;
    logic                s_rready  = 1'b0;
    logic                xd_toggle;
    logic [9:0]          xd_index;
    logic [31:0]         xd_data;

    tile_xfer_bridge i_tile_xfer_bridge (
        .clk(clk), .rst_n(rst_n),
        .s_awid(s_awid), .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bid(s_bid), .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_arid(s_arid), .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rid(s_rid), .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast),
        .s_rvalid(s_rvalid), .s_rready(s_rready),
        .xd_toggle(xd_toggle), .xd_index(xd_index), .xd_data(xd_data)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model of the tile contents
    logic [31:0] model [DEPTH];

    typedef struct { logic [ID_W-1:0] id; logic [DATA_W-1:0] data; string req; } rd_exp_t;
    typedef struct { logic [9:0] idx; logic [31:0] data; } xd_exp_t;
    rd_exp_t rd_q[$];
    xd_exp_t xd_q[$];

    function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
        logic [31:0] w;
        if (a[ADDR_W-1:4] == '0) begin
            case (a[3:2])
                2'd0: w = 32'h7053_3200;
                2'd1: w = 32'h0000_0100;
                2'd2: w = 32'h0000_0001;
                default: w = 32'h0;
            endcase
        end else if (a[ADDR_W-1:12] == 26'h1) begin
            w = model[a[11:2]];
        end else begin
            w = 32'h0;
        end
        return DATA_W'(w) << (32 * a[3:2]);
    endfunction

    // Driver: one write transaction, with expected handoff pushed to the scoreboard
    task automatic do_write(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] wd, input logic [15:0] strb);
        bit          tile = (a[ADDR_W-1:12] == 26'h1);
        logic [1:0]  ln   = a[3:2];
        logic [9:0]  idx  = a[11:2];
        logic [31:0] lw   = wd[32*ln +: 32];
        logic [3:0]  ls   = strb[4*ln +: 4];
        logic [31:0] merged;
        logic        prev_tog;
        @(negedge clk);
        s_awid = id; s_awaddr = a; s_awvalid = 1'b1;
        while (!s_awready) @(negedge clk);
        @(negedge clk);
        s_awvalid = 1'b0;
        check(s_wready && !s_awready, "R2", "data phase ready", {s_wready, s_awready}, 2'b10);
        prev_tog = xd_toggle;
        s_wdata = wd; s_wstrb = strb; s_wvalid = 1'b1;
        @(negedge clk);
        s_wvalid = 1'b0;
        check(s_bvalid && s_bid == id, "R4", "bid echo", {s_bvalid, s_bid}, {1'b1, id});
        check(s_bresp == 2'b00, "R5", "bresp okay", s_bresp, 2'b00);
        if (tile) begin
            merged = model[idx];
            for (int b = 0; b < 4; b++) begin
                if (ls[b]) merged[8*b +: 8] = lw[8*b +: 8];
            end
            model[idx] = merged;
            check(xd_toggle != prev_tog, "R10", "toggle flip", xd_toggle, ~prev_tog);
            check(xd_index == idx, "R10", "handoff index", xd_index, idx);
            check(xd_data == merged, "R10", "handoff data", xd_data, merged);
            xd_q.push_back('{idx: idx, data: merged});
        end else begin
            check(xd_toggle == prev_tog, "R7", "no toggle on non-tile write", xd_toggle, prev_tog);
        end
        @(negedge clk);
        check(s_bvalid && !s_awready, "R2", "response held", {s_bvalid, s_awready}, 2'b10);
        s_bready = 1'b1;
        @(negedge clk);
        s_bready = 1'b0;
        check(!s_bvalid && s_awready, "R2", "response released", {s_bvalid, s_awready}, 2'b01);
        repeat (6) @(negedge clk);
    endtask

    // Driver: one read, expected response pushed to the scoreboard
    task automatic do_read(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a, input string req);
        rd_q.push_back('{id: id, data: exp_read(a), req: req});
        @(negedge clk);
        s_arid = id; s_araddr = a; s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        wait (rd_q.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: compares read responses, stalls one cycle to probe the hold
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && s_rvalid) begin
                if (rd_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected read response", s_rdata, '0);
                end else begin
                    logic [DATA_W-1:0] held;
                    check(s_rdata == rd_q[0].data, rd_q[0].req, "read data", s_rdata, rd_q[0].data);
                    check(s_rid == rd_q[0].id, "R4", "rid echo", s_rid, rd_q[0].id);
                    check(s_rresp == 2'b00 && s_rlast, "R5", "rresp/rlast", {s_rresp, s_rlast}, 3'b001);
                    held = s_rdata;
                    @(negedge clk);
                    check(s_rvalid && s_rdata == held && !s_arready, "R3", "read held",
                          s_rdata, held);
                    s_rready = 1'b1;
                    @(negedge clk);
                    s_rready = 1'b0;
                    check(!s_rvalid && s_arready, "R3", "read released", {s_rvalid, s_arready}, 2'b01);
                    void'(rd_q.pop_front());
                end
            end
        end
    end

    // Receiver-domain model: 3-stage synchronizer, edge detect, shadow copy
    logic [2:0]  rsync;
    logic [31:0] shadow [DEPTH];
    xd_exp_t     xd_got;

    always @(posedge rclk) begin
        if (!rst_n) begin
            rsync <= 3'b000;
        end else begin
            rsync <= {rsync[1:0], xd_toggle};
            if (rsync[2] ^ rsync[1]) begin
                shadow[xd_index] <= xd_data;
                if (xd_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected handoff", xd_index, '0);
                end else begin
                    xd_got = xd_q.pop_front();
                    check(xd_index == xd_got.idx, "R11", "received index", xd_index, xd_got.idx);
                    check(xd_data == xd_got.data, "R11", "received data", xd_data, xd_got.data);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(s_awready && s_arready, "R1", "ready after reset", {s_awready, s_arready}, 2'b11);
        check(!s_bvalid && !s_rvalid, "R1", "no valid after reset", {s_bvalid, s_rvalid}, 2'b00);
        check(xd_toggle == 1'b0 && xd_index == '0 && xd_data == '0, "R1", "handoff cleared",
              {xd_toggle, xd_index, xd_data}, '0);

        // R6: identity window, each lane
        do_read(4'h3, 38'h000, "R6");
        do_read(4'h5, 38'h004, "R6");
        do_read(4'h9, 38'h008, "R6");
        do_read(4'hC, 38'h00C, "R6");

        // R7: unmapped reads
        do_read(4'h1, 38'h010, "R7");
        do_read(4'h2, 38'h2000, "R7");
        do_read(4'h4, 38'h20_0000_1004, "R7");

        // R7: writes outside the tile window are discarded
        do_write(4'h6, 38'h004, {128{1'b1}}, 16'hFFFF);
        do_write(4'h7, 38'h2004, {128{1'b1}}, 16'hFFFF);
        do_read(4'h8, 38'h004, "R7");

        // R8/R10: full-lane tile writes at edges and in every lane
        do_write(4'hA, 38'h1000, 128'h0000_0000_0000_0000_0000_0000_CAFE_F00D, 16'h000F);
        do_write(4'hB, 38'h1004, 128'h0000_0000_0000_0000_1234_5678_0000_0000, 16'h00F0);
        do_write(4'hD, 38'h1FFC, 128'hDEAD_BEEF_0000_0000_0000_0000_0000_0000, 16'hF000);
        do_write(4'hE, 38'h1018, 128'h0000_0000_A5A5_5A5A_0000_0000_0000_0000, 16'h0F00);

        // R9: single-byte strobe merges into the stored word
        do_write(4'hF, 38'h1018, 128'h0000_0000_0011_2233_0000_0000_0000_0000, 16'h0200);
        check(model[6] == 32'hA5A5_225A, "R9", "bench merge reference", model[6], 32'hA5A5_225A);
        // R9: strobes only outside the selected lane leave the word unchanged
        do_write(4'h0, 38'h1004, {128{1'b1}}, 16'h000F);

        // R8: read back each entry in its lane
        do_read(4'h1, 38'h1000, "R8");
        do_read(4'h2, 38'h1004, "R8");
        do_read(4'h3, 38'h1FFC, "R8");
        do_read(4'h4, 38'h1018, "R9");

        // R11: everything reached the receiver domain
        repeat (20) @(negedge clk);
        check(xd_q.size() == 0, "R11", "all handoffs received", xd_q.size(), 0);
        check(shadow[0] == model[0], "R11", "shadow entry 0", shadow[0], model[0]);
        check(shadow[1] == model[1], "R11", "shadow entry 1", shadow[1], model[1]);
        check(shadow[1023] == model[1023], "R11", "shadow entry 1023", shadow[1023], model[1023]);
        check(shadow[6] == model[6], "R11", "shadow entry 6", shadow[6], model[6]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule : test_tile_xfer_bridge